// File: doc/BRIEF.md
# Reset Source Control Unit

This unit merges the reset requests of a device into one active-high reset output. Four requests feed it. The first is an asynchronous power-on reset. The second is an external active-low reset pin. The third is a brown-out detector output. The fourth is a pair of watchdog event pulses, one for a timeout and one for a window violation. Two configuration inputs decide whether the external pin acts as a reset at all. A synchronizer and a run-length filter remove short pulses on that pin before it can reset anything.

The brown-out path is gated by a two-bit configuration code together with a software enable bit. The brown-out circuit reports itself ready only after a fixed settling time. The unit has two 8-bit registers. The control register holds the software enable and the ready flag. The cause register holds sticky flags that record which source produced a reset. The unit only reads the reset pin and never drives it. The unit is never cleared by its own reset output, so the flags survive every reset except power-on.

Top module: `rsu_top`

## Requirements
- R1: While `por_n` is low, and for two clock edges after it rises, `dev_rst` is 1. After power-on the control register (address 0) reads 0x80 and the cause register (address 1) reads 0x00.
- R2: The pin reset is disabled only when `cfg_pin_en` = 0 and `cfg_lvp` = 0. In that case a low level on `rst_pin_n` of any length leaves `dev_rst` at 0 and leaves cause bit 3 at 0. Every other combination of the two bits enables it.
- R3: When the pin reset is enabled, `rst_pin_n` is first synchronized by two flops. It must then be seen low for 4 consecutive samples. `dev_rst` rises on the 6th rising edge after the pin falls and stays 1 while the pin is low. It falls on the 6th edge after the pin returns high. A low pulse of 3 cycles or fewer has no effect.
- R4: The brown-out code `cfg_bor_mode` decodes as follows: 00 means brown-out reset off, 01 means it follows the software enable, and 10 or 11 mean it is always on.
- R5: Control register bit 7 is the software enable and can be read and written under every code. Bits 6 to 1 always read 0, and writes to them are ignored.
- R6: Control register bit 0 (ready) reads 1 from the 16th rising edge after the effective brown-out enable becomes 1. It reads 0 in the same cycle in which the effective enable becomes 0.
- R7: While ready is 1, a high `bor_trip` raises `dev_rst` on the 2nd rising edge after it rises. A brown-out reset sets cause bit 2 and sets the software enable back to 1.
- R8: A one-cycle pulse on `wdt_timeout` or `wdt_window` raises `dev_rst` from the next rising edge for 8 cycles. A timeout sets cause bit 0 and a window violation sets cause bit 1.
- R9: Cause flags (bit 0 watchdog timeout, bit 1 window violation, bit 2 brown-out, bit 3 pin, bits 7 to 4 read 0) stay set through pin, brown-out and watchdog resets. Writing 0 to a flag bit clears it. Writing 1 leaves it unchanged. Only power-on clears the flags otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous active-low power-on reset |
| cfg_pin_en | input | 1 | Configuration: pin reset enable |
| cfg_lvp | input | 1 | Configuration: low-voltage programming, also enables the pin reset |
| cfg_bor_mode | input | 2 | Configuration: brown-out mode code |
| rst_pin_n | input | 1 | External active-low reset pin (input only) |
| bor_trip | input | 1 | Brown-out detector output, high on low supply |
| wdt_timeout | input | 1 | Watchdog timeout event pulse |
| wdt_window | input | 1 | Watchdog window-violation event pulse |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register address: 0 control, 1 cause |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational from `reg_addr`) |
| dev_rst | output | 1 | Active-high combined device reset |

## Verification
The due times differ by source:

| Result | Due |
|---|---|
| Pin reset (assert and release) | 6th rising edge after the pin changes |
| Brown-out reset | 2nd edge after `bor_trip` rises |
| Watchdog reset | The edge that samples the pulse, then held for exactly 8 cycles |
| Ready flag | 16th edge after the write that enables it; drops in the same cycle as a disable |
| Cause flags and software-enable restore | One edge after their event |
| Register reads | Combinational |

The bench drives every input on the falling edge and counts whole rising edges before it samples. Where a window matters it samples both the last cycle before the result is due and the first cycle after, so an early or late result is caught.

// File: rtl/rsu_pkg.sv
package rsu_pkg;
  localparam int REG_W        = 8;
  localparam int SWEN_BIT     = 7;
  localparam int RDY_BIT      = 0;
  localparam int NUM_CAUSE    = 4;
  localparam logic ADDR_BORCTL = 1'b0;
  localparam logic ADDR_CAUSE  = 1'b1;

  typedef enum logic [1:0] {
    BORM_OFF = 2'b00,
    BORM_SW  = 2'b01,
    BORM_ON  = 2'b10,
    BORM_ON2 = 2'b11
  } bor_mode_e;

  typedef struct packed {
    logic pin;
    logic bor;
    logic win;
    logic wdt;
  } cause_t;
endpackage

// File: rtl/rsu_sync.sv
module rsu_sync #(
  parameter int               WIDTH   = 1,
  parameter int               STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [WIDTH-1:0] stage_d;
    if (s == 0) begin : g_first
      assign stage_d = d;
    end else begin : g_next
      assign stage_d = stage_q[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= RST_VAL;
      else        stage_q[s] <= stage_d;
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/rsu_pin_filter.sv
module rsu_pin_filter #(
  parameter int RUN_LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic pin_sync,
  output logic hold_rst
);
  localparam int CNT_W = (RUN_LEN > 1) ? $clog2(RUN_LEN) : 1;
  localparam logic [CNT_W-1:0] RUN_LAST = CNT_W'(RUN_LEN - 1);

  logic             sample;
  logic             state_q, state_d;
  logic [CNT_W-1:0] run_q, run_d;

  assign sample = en & ~pin_sync;

  always_comb begin
    state_d = state_q;
    run_d   = run_q;
    if (sample == state_q) begin
      run_d = '0;
    end else if (run_q == RUN_LAST) begin
      state_d = sample;
      run_d   = '0;
    end else begin
      run_d = run_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= 1'b0;
      run_q   <= '0;
    end else begin
      state_q <= state_d;
      run_q   <= run_d;
    end
  end

  assign hold_rst = state_q;

  // R3: the filtered state only flips after a full run of differing samples
  p_run_before_flip_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(state_q) |-> ($past(run_q) == RUN_LAST) && $past(sample));

  // R2: a disabled pin can never start a reset
  p_pin_disabled_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !state_q) |=> !state_q);
endmodule

// File: rtl/rsu_bor_gate.sv
module rsu_bor_gate #(
  parameter int SETTLE = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode,
  input  logic       sw_en,
  input  logic       trip_sync,
  output logic       ready,
  output logic       bor_rst
);
  import rsu_pkg::*;

  localparam int CNT_W = (SETTLE > 1) ? $clog2(SETTLE) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SETTLE - 1);

  logic             eff;
  logic             rdy_q, rdy_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    case (bor_mode_e'(mode))
      BORM_OFF: eff = 1'b0;
      BORM_SW:  eff = sw_en;
      default:  eff = 1'b1;
    endcase
  end

  always_comb begin
    cnt_d = cnt_q;
    rdy_d = rdy_q;
    if (!eff) begin
      cnt_d = '0;
      rdy_d = 1'b0;
    end else if (!rdy_q) begin
      if (cnt_q == CNT_LAST) rdy_d = 1'b1;
      else                   cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      rdy_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      rdy_q <= rdy_d;
    end
  end

  assign ready   = rdy_q & eff;
  assign bor_rst = ready & trip_sync;

  // R6: ready only rises once the enable was already present the cycle before
  p_rdy_after_enable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> $past(eff));

  // R6: the settling counter must have run to its end before ready is set
  p_settle_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rdy_q) |-> ($past(cnt_q) == CNT_LAST));
endmodule

// File: rtl/rsu_regs.sv
module rsu_regs (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr,
  input  logic                      addr,
  input  logic [rsu_pkg::REG_W-1:0] wdata,
  input  logic                      ready,
  input  logic                      ev_wdt,
  input  logic                      ev_win,
  input  logic                      ev_bor,
  input  logic                      ev_pin,
  output logic                      sw_en,
  output logic [rsu_pkg::REG_W-1:0] rdata
);
  import rsu_pkg::*;

  logic   sw_en_q, sw_en_d;
  cause_t cause_q, cause_d;
  cause_t set_mask, clr_mask;
  logic   wr_ctl, wr_cause;
  logic   unused_wbits;

  assign wr_ctl       = wr && (addr == ADDR_BORCTL);
  assign wr_cause     = wr && (addr == ADDR_CAUSE);
  assign unused_wbits = ^wdata[SWEN_BIT-1:NUM_CAUSE];

  always_comb begin
    set_mask = '{pin: ev_pin, bor: ev_bor, win: ev_win, wdt: ev_wdt};
    clr_mask = wr_cause ? cause_t'(~wdata[NUM_CAUSE-1:0]) : cause_t'('0);
    cause_d  = (cause_q & ~clr_mask) | set_mask;
  end

  always_comb begin
    sw_en_d = sw_en_q;
    if (ev_bor)      sw_en_d = 1'b1;
    else if (wr_ctl) sw_en_d = wdata[SWEN_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sw_en_q <= 1'b1;
      cause_q <= '0;
    end else begin
      sw_en_q <= sw_en_d;
      cause_q <= cause_d;
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == ADDR_BORCTL) begin
      rdata[SWEN_BIT] = sw_en_q;
      rdata[RDY_BIT]  = ready;
    end else begin
      rdata[NUM_CAUSE-1:0] = cause_q;
    end
  end

  assign sw_en = sw_en_q;

  // R7: a brown-out reset returns the software enable to 1
  p_swen_restore_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_bor |=> sw_en_q);

  // R9: a set flag survives any cycle without a cause-register write
  p_flag_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cause_q != '0 && !wr_cause) |=> ((cause_q & $past(cause_q)) == $past(cause_q)));

  // R8: a watchdog timeout event is recorded on the next edge
  p_wdt_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wdt |=> cause_q.wdt);
endmodule

// File: rtl/rsu_top.sv
module rsu_top #(
  parameter int PIN_RUN     = 4,
  parameter int BOR_SETTLE  = 16,
  parameter int WDT_HOLD    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       cfg_pin_en,
  input  logic       cfg_lvp,
  input  logic [1:0] cfg_bor_mode,
  input  logic       rst_pin_n,
  input  logic       bor_trip,
  input  logic       wdt_timeout,
  input  logic       wdt_window,
  input  logic       reg_wr,
  input  logic       reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       dev_rst
);
  localparam int HOLD_W = $clog2(WDT_HOLD + 1);

  logic              rst_n_int;
  logic              pin_sync, trip_sync;
  logic              pin_en, pin_hold;
  logic              sw_en, bor_ready, bor_rst;
  logic              wdt_ev;
  logic [HOLD_W-1:0] hold_q, hold_d;
  logic              wdt_rst;

  rsu_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_rst_sync (
    .clk(clk), .rst_n(por_n), .d(1'b1), .q(rst_n_int));

  rsu_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_pin_sync (
    .clk(clk), .rst_n(rst_n_int), .d(rst_pin_n), .q(pin_sync));

  rsu_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_trip_sync (
    .clk(clk), .rst_n(rst_n_int), .d(bor_trip), .q(trip_sync));

  assign pin_en = cfg_pin_en | cfg_lvp;

  rsu_pin_filter #(.RUN_LEN(PIN_RUN)) u_pin_filter (
    .clk(clk), .rst_n(rst_n_int), .en(pin_en), .pin_sync(pin_sync),
    .hold_rst(pin_hold));

  rsu_bor_gate #(.SETTLE(BOR_SETTLE)) u_bor_gate (
    .clk(clk), .rst_n(rst_n_int), .mode(cfg_bor_mode), .sw_en(sw_en),
    .trip_sync(trip_sync), .ready(bor_ready), .bor_rst(bor_rst));

  rsu_regs u_regs (
    .clk(clk), .rst_n(rst_n_int), .wr(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .ready(bor_ready), .ev_wdt(wdt_timeout),
    .ev_win(wdt_window), .ev_bor(bor_rst), .ev_pin(pin_hold),
    .sw_en(sw_en), .rdata(reg_rdata));

  assign wdt_ev = wdt_timeout | wdt_window;

  always_comb begin
    hold_d = hold_q;
    if (wdt_ev)              hold_d = HOLD_W'(WDT_HOLD);
    else if (hold_q != '0)   hold_d = hold_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) hold_q <= '0;
    else            hold_q <= hold_d;
  end

  assign wdt_rst = (hold_q != '0);
  assign dev_rst = ~rst_n_int | pin_hold | bor_rst | wdt_rst;

  // R8: any watchdog event puts the device into reset on the next edge
  p_wdt_hold_r8: assert property (@(posedge clk) disable iff (!rst_n_int)
    wdt_ev |=> dev_rst);
endmodule

// File: tb/rsu_top_tb_top.sv
module rsu_top_tb_top;
  logic       clk = 1'b0;
  logic       por_n, cfg_pin_en, cfg_lvp, rst_pin_n, bor_trip;
  logic       wdt_timeout, wdt_window, reg_wr, reg_addr, dev_rst;
  logic [1:0] cfg_bor_mode;
  logic [7:0] reg_wdata, reg_rdata;
  int         total = 0;
  int         bad = 0;

  always #5 clk = ~clk;

  rsu_top dut_i (
    .clk(clk), .por_n(por_n), .cfg_pin_en(cfg_pin_en), .cfg_lvp(cfg_lvp),
    .cfg_bor_mode(cfg_bor_mode), .rst_pin_n(rst_pin_n), .bor_trip(bor_trip),
    .wdt_timeout(wdt_timeout), .wdt_window(wdt_window), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .dev_rst(dev_rst));

  // [6] pin_en [5] lvp [4:3] bor mode [2] sw enable [1] expect pin reset [0] expect bor reset
  localparam logic [6:0] VECS [8] = '{
    7'b0_0_01_1_0_1, 7'b1_0_00_1_1_0, 7'b0_1_10_0_1_1, 7'b1_1_11_0_1_1,
    7'b0_0_01_0_0_0, 7'b1_0_00_0_1_0, 7'b0_1_01_1_1_1, 7'b0_0_11_1_0_1};

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic a, input logic [7:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = 8'h00;
  endtask

  task automatic rd_reg(input logic a, output logic [7:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    por_n = 1'b0; cfg_pin_en = 1'b1; cfg_lvp = 1'b0; cfg_bor_mode = 2'b01;
    rst_pin_n = 1'b1; bor_trip = 1'b0; wdt_timeout = 1'b0; wdt_window = 1'b0;
    reg_wr = 1'b0; reg_addr = 1'b0; reg_wdata = 8'h00;

    // R1 reset state
    step(3);
    chk("R1 dev_rst during por", {7'd0, dev_rst}, 8'h01);
    por_n = 1'b1;
    step(1);
    chk("R1 dev_rst one edge after por", {7'd0, dev_rst}, 8'h01);
    step(1);
    chk("R1 dev_rst released", {7'd0, dev_rst}, 8'h00);
    rd_reg(1'b0, rd); chk("R1 control reset value", rd, 8'h80);
    rd_reg(1'b1, rd); chk("R1 cause reset value", rd, 8'h00);

    // R6 ready timing and immediate drop
    step(20);
    wr_reg(1'b0, 8'h00);
    rd_reg(1'b0, rd); chk("R6 ready drops with write of 0", rd, 8'h00);
    wr_reg(1'b0, 8'h80);
    step(15);
    rd_reg(1'b0, rd); chk("R6 ready not yet at 15", rd, 8'h80);
    step(1);
    rd_reg(1'b0, rd); chk("R6 ready at 16", rd, 8'h81);
    cfg_bor_mode = 2'b00;
    rd_reg(1'b0, rd); chk("R6 ready drops same cycle as disable", rd, 8'h80);
    step(1);
    cfg_bor_mode = 2'b01;

    // R3 short pulse ignored
    rst_pin_n = 1'b0;
    step(3);
    rst_pin_n = 1'b1;
    for (int i = 0; i < 10; i++) begin
      step(1);
      chk("R3 3-cycle glitch ignored", {7'd0, dev_rst}, 8'h00);
    end
    rd_reg(1'b1, rd); chk("R3 no pin flag from glitch", rd, 8'h00);

    // R3 exact assert and release timing
    rst_pin_n = 1'b0;
    step(5);
    chk("R3 not yet asserted at edge 5", {7'd0, dev_rst}, 8'h00);
    step(1);
    chk("R3 asserted at edge 6", {7'd0, dev_rst}, 8'h01);
    step(10);
    chk("R3 held while pin low", {7'd0, dev_rst}, 8'h01);
    rst_pin_n = 1'b1;
    step(5);
    chk("R3 still held at edge 5", {7'd0, dev_rst}, 8'h01);
    step(1);
    chk("R3 released at edge 6", {7'd0, dev_rst}, 8'h00);
    wr_reg(1'b1, 8'h00);

    // R2 R4 configuration table
    for (int v = 0; v < 8; v++) begin
      logic [6:0] e;
      e = VECS[v];
      cfg_pin_en = e[6]; cfg_lvp = e[5]; cfg_bor_mode = e[4:3];
      wr_reg(1'b0, {e[2], 7'd0});
      step(20);
      rd_reg(1'b0, rd); chk("R4 R5 control readback per mode", rd, {e[2], 6'd0, e[0]});
      bor_trip = 1'b1;
      step(2);
      chk("R4 brown-out reset per mode", {7'd0, dev_rst}, {7'd0, e[0]});
      bor_trip = 1'b0;
      step(4);
      chk("R4 brown-out reset ends", {7'd0, dev_rst}, 8'h00);
      rst_pin_n = 1'b0;
      step(6);
      chk("R2 pin reset per config", {7'd0, dev_rst}, {7'd0, e[1]});
      rst_pin_n = 1'b1;
      step(7);
      chk("R2 pin reset ends", {7'd0, dev_rst}, 8'h00);
      rd_reg(1'b1, rd); chk("R9 cause flags per config", rd, {4'd0, e[1], e[0], 2'b00});
      wr_reg(1'b1, 8'h00);
    end
    cfg_pin_en = 1'b1; cfg_lvp = 1'b0; cfg_bor_mode = 2'b01;

    // R8 watchdog timeout and window
    wdt_timeout = 1'b1;
    step(1);
    wdt_timeout = 1'b0;
    chk("R8 timeout reset starts", {7'd0, dev_rst}, 8'h01);
    rd_reg(1'b1, rd); chk("R8 timeout flag", rd, 8'h01);
    step(7);
    chk("R8 still held at cycle 8", {7'd0, dev_rst}, 8'h01);
    step(1);
    chk("R8 released after 8", {7'd0, dev_rst}, 8'h00);
    wdt_window = 1'b1;
    step(1);
    wdt_window = 1'b0;
    chk("R8 window reset starts", {7'd0, dev_rst}, 8'h01);
    step(9);
    rd_reg(1'b1, rd); chk("R8 window flag added", rd, 8'h03);

    // R9 sticky flags and write-0 clear
    rst_pin_n = 1'b0;
    step(6);
    rst_pin_n = 1'b1;
    step(7);
    rd_reg(1'b1, rd); chk("R9 flags survive pin reset", rd, 8'h0B);
    wr_reg(1'b1, 8'h09);
    rd_reg(1'b1, rd); chk("R9 write 0 clears only those bits", rd, 8'h09);
    wr_reg(1'b1, 8'hFF);
    rd_reg(1'b1, rd); chk("R9 write 1 no effect", rd, 8'h09);
    wr_reg(1'b1, 8'h00);
    rd_reg(1'b1, rd); chk("R9 full clear", rd, 8'h00);

    // R5 reserved bits and enable writable while off
    cfg_bor_mode = 2'b00;
    wr_reg(1'b0, 8'hFF);
    rd_reg(1'b0, rd); chk("R5 reserved bits read 0", rd, 8'h80);
    wr_reg(1'b0, 8'h7E);
    rd_reg(1'b0, rd); chk("R5 enable cleared with mode off", rd, 8'h00);

    // R7 brown-out restores software enable
    cfg_bor_mode = 2'b10;
    step(20);
    rd_reg(1'b0, rd); chk("R7 forced-on ready with enable 0", rd, 8'h01);
    bor_trip = 1'b1;
    step(1);
    chk("R7 not yet reset at edge 1", {7'd0, dev_rst}, 8'h00);
    step(1);
    chk("R7 reset at edge 2", {7'd0, dev_rst}, 8'h01);
    bor_trip = 1'b0;
    step(4);
    rd_reg(1'b0, rd); chk("R7 enable back to 1", rd, 8'h81);
    rd_reg(1'b1, rd); chk("R7 brown-out flag", rd, 8'h04);

    // R1 second power-on clears everything
    cfg_bor_mode = 2'b01;
    wr_reg(1'b0, 8'h00);
    por_n = 1'b0;
    step(2);
    chk("R1 dev_rst on second por", {7'd0, dev_rst}, 8'h01);
    por_n = 1'b1;
    step(2);
    rd_reg(1'b0, rd); chk("R1 enable back after por", rd, 8'h80);
    rd_reg(1'b1, rd); chk("R1 flags cleared by por", rd, 8'h00);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule